// File: doc/BRIEF.md
# Hash Configuration Packet Parser

This block sits on the byte-wide input bus of a hashing accelerator. Message bytes and configuration bytes travel on that same bus. A 2-bit mode field marks each byte as one or the other, and a valid strobe says when a byte is present. The parser collects configuration bytes into a fixed ten-byte packet and builds three hash parameters from it: the key length in bytes, the digest length in bytes, and the total message length.

The parser writes the three parameters together, and only when a packet arrives complete. It then drives them to the hashing core without a break. They keep their values across any number of hash runs until the next complete packet replaces them, so a host can configure once and hash many messages. A one-cycle update strobe tells the core that fresh parameters were written. Any break in configuration mode throws away a half-received packet.

Top module: `cfgp_parser`

## Requirements
- R1: A byte is taken only on a cycle where `in_valid` is 1 and `in_mode` is 2'b01. Bytes under mode 2'b10 (message data), 2'b00 (idle) or 2'b11 (reserved) never change any output.
- R2: Inside a packet, byte position 0 carries the key length and position 1 carries the digest length. Positions 2 to 9 carry the message length in little-endian order, with position 2 as the least significant byte.
- R3: `key_len`, `digest_len` and `msg_len` all change together, and only on the clock edge that takes the tenth byte of a packet. Earlier bytes leave the outputs untouched.
- R4: `cfg_updated` is 1 for exactly the one cycle after the edge that takes a packet's tenth byte, and 0 at every other time.
- R5: Any cycle whose mode is not 2'b01 throws away a partial packet without changing the outputs. The next configuration byte is then treated as position 0.
- R6: A cycle with mode 2'b01 and `in_valid` at 0 keeps the position reached inside the packet.
- R7: A synchronous active-high reset sets the key length to 0, the digest length to 32, the message length to 0 and `cfg_updated` to 0.
- R8: A new packet may start on the cycle right after a previous packet's last byte. Both packets are taken and written, and the outputs then hold the second one's values until another packet completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A byte is present on `in_byte` |
| in_mode | input | 2 | Bus mode: 00 idle, 01 configuration, 10 data, 11 reserved |
| in_byte | input | 8 | Input byte |
| key_len | output | 8 | Committed key length in bytes |
| digest_len | output | 8 | Committed digest length in bytes |
| msg_len | output | 64 | Committed total message length |
| cfg_updated | output | 1 | One-cycle pulse after a packet is written |

## Verification
Two things can land in the same cycle: a packet is written, and the next packet begins. The same clock edge that takes the last byte also sends the position counter back to zero. When packets are sent back to back, the update pulse is high on the cycle where the first byte of the next packet is being taken. The bench provokes this with packets that have no gap between them, and also with random mode and valid patterns. A cycle-accurate model in the bench judges every cycle. It requires one pulse per completed packet, with the outputs showing the first packet's values on that pulse cycle, and the second packet's values only after its own tenth byte.

// File: rtl/cfgp_pkg.sv
`timescale 1ns/1ps
package cfgp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_CFG  = 2'b01,
        MODE_DATA = 2'b10,
        MODE_RSVD = 2'b11
    } bus_mode_e;

    typedef struct packed {
        logic [BYTE_W-1:0] dig_len;
        logic [BYTE_W-1:0] key_len;
    } cfg_hdr_t;

    function automatic logic is_cfg_beat(input logic valid, input bus_mode_e mode);
        return valid && (mode == MODE_CFG);
    endfunction

endpackage

// File: rtl/cfgp_seq.sv
`timescale 1ns/1ps
module cfgp_seq
    import cfgp_pkg::*;
#(
    parameter int PKT_BYTES = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  bus_mode_e in_mode,
    output logic      beat,
    output logic      last_beat
);
    localparam int IDX_W = $clog2(PKT_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_BYTES - 1);

    logic [IDX_W-1:0] idx_q;

    assign beat      = is_cfg_beat(in_valid, in_mode);
    assign last_beat = beat && (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (in_mode != MODE_CFG) begin
            idx_q <= '0;
        end else if (beat) begin
            idx_q <= last_beat ? '0 : idx_q + 1'b1;
        end
    end

    // R2: the position counter never leaves the packet
    p_idx_range_r2: assert property (@(posedge clk) disable iff (rst)
        idx_q <= LAST_IDX);

    // R5: leaving configuration mode restarts the packet
    p_abort_r5: assert property (@(posedge clk) disable iff (rst)
        (in_mode != MODE_CFG) |=> (idx_q == '0));

    // R6: an idle cycle in configuration mode keeps the position
    p_gap_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (in_mode == MODE_CFG && !in_valid) |=> $stable(idx_q));

endmodule

// File: rtl/cfgp_assemble.sv
`timescale 1ns/1ps
module cfgp_assemble
    import cfgp_pkg::*;
#(
    parameter int PKT_BYTES = 10,
    parameter int LEN_BYTES = 8,
    parameter int DIG_RST   = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        beat,
    input  logic                        last_beat,
    input  logic [BYTE_W-1:0]           byte_in,
    output cfg_hdr_t                    hdr,
    output logic [LEN_BYTES*BYTE_W-1:0] len,
    output logic                        updated
);
    localparam int STAGE_W = (PKT_BYTES - 1) * BYTE_W;
    localparam int FULL_W  = PKT_BYTES * BYTE_W;
    localparam int LEN_W   = LEN_BYTES * BYTE_W;

    logic [STAGE_W-1:0] stage_q;
    logic [FULL_W-1:0]  full;
    cfg_hdr_t           hdr_q;
    logic [LEN_W-1:0]   len_q;
    logic               upd_q;

    // earliest byte sits lowest once the packet is complete
    assign full = {byte_in, stage_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else if (beat) begin
            stage_q <= full[FULL_W-1:BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q.key_len <= '0;
            hdr_q.dig_len <= BYTE_W'(DIG_RST);
            len_q         <= '0;
            upd_q         <= 1'b0;
        end else begin
            upd_q <= last_beat;
            if (last_beat) begin
                hdr_q.key_len <= full[BYTE_W-1:0];
                hdr_q.dig_len <= full[2*BYTE_W-1:BYTE_W];
                len_q         <= full[2*BYTE_W +: LEN_W];
            end
        end
    end

    assign hdr     = hdr_q;
    assign len     = len_q;
    assign updated = upd_q;

endmodule

// File: rtl/cfgp_parser.sv
`timescale 1ns/1ps
module cfgp_parser
    import cfgp_pkg::*;
#(
    parameter int LEN_BYTES = 8,
    parameter int DIG_RST   = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [1:0]                  in_mode,
    input  logic [7:0]                  in_byte,
    output logic [7:0]                  key_len,
    output logic [7:0]                  digest_len,
    output logic [LEN_BYTES*8-1:0]      msg_len,
    output logic                        cfg_updated
);
    localparam int PKT_BYTES = 2 + LEN_BYTES;

    bus_mode_e mode;
    logic      beat;
    logic      last_beat;
    cfg_hdr_t  hdr;

    assign mode = bus_mode_e'(in_mode);

    cfgp_seq #(.PKT_BYTES(PKT_BYTES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_mode   (mode),
        .beat      (beat),
        .last_beat (last_beat)
    );

    cfgp_assemble #(
        .PKT_BYTES (PKT_BYTES),
        .LEN_BYTES (LEN_BYTES),
        .DIG_RST   (DIG_RST)
    ) u_asm (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat),
        .last_beat (last_beat),
        .byte_in   (in_byte),
        .hdr       (hdr),
        .len       (msg_len),
        .updated   (cfg_updated)
    );

    assign key_len    = hdr.key_len;
    assign digest_len = hdr.dig_len;

    // R1: a write always follows a taken configuration byte
    p_cfg_only_r1: assert property (@(posedge clk) disable iff (rst)
        cfg_updated |-> $past(in_valid && in_mode == 2'b01));

    // R3: outputs are quiet unless a write just happened
    p_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_updated |-> $stable({key_len, digest_len, msg_len}));

    // R4: the update strobe lasts one cycle
    p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        cfg_updated |=> !cfg_updated);

    // R7: values right after reset
    p_reset_vals_r7: assert property (@(posedge clk)
        $past(rst) |-> (key_len == 8'd0 && digest_len == 8'(DIG_RST)
                        && msg_len == '0 && !cfg_updated));

endmodule

// File: tb/tb_cfgp_parser.sv
`timescale 1ns/1ps
module tb_cfgp_parser;
    localparam int LB = 8;
    localparam int PB = LB + 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [1:0]    in_mode = 2'b00;
    logic [7:0]    in_byte = 8'h00;
    logic [7:0]    key_len, digest_len;
    logic [LB*8-1:0] msg_len;
    logic          cfg_updated;

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    int          m_cnt = 0;
    logic [7:0]  m_buf [PB];
    logic [7:0]  e_key = 8'd0;
    logic [7:0]  e_dig = 8'd32;
    logic [63:0] e_len = 64'd0;
    logic        e_upd = 1'b0;

    always #2.5 clk = ~clk;

    cfgp_parser dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_byte(in_byte), .key_len(key_len), .digest_len(digest_len),
        .msg_len(msg_len), .cfg_updated(cfg_updated)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] le_len(input logic [7:0] b [PB]);
        logic [63:0] v = '0;
        for (int i = 0; i < LB; i++) v[i*8 +: 8] = b[2+i];
        return v;
    endfunction

    // compare outputs with the model, then drive one cycle and advance the model
    task automatic cyc(input logic v, input logic [1:0] m, input logic [7:0] d);
        @(negedge clk);
        check("R3 key_len", 64'(key_len), 64'(e_key));
        check("R3 digest_len", 64'(digest_len), 64'(e_dig));
        check("R3 msg_len", msg_len, e_len);
        check("R4 cfg_updated", 64'(cfg_updated), 64'(e_upd));
        in_valid = v; in_mode = m; in_byte = d;
        e_upd = 1'b0;
        if (m != 2'b01) begin
            m_cnt = 0;
        end else if (v) begin
            m_buf[m_cnt] = d;
            if (m_cnt == PB - 1) begin
                e_key = m_buf[0];
                e_dig = m_buf[1];
                e_len = le_len(m_buf);
                e_upd = 1'b1;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
    endtask

    task automatic send_pkt(input logic [7:0] k, input logic [7:0] g,
                            input logic [63:0] l, input bit gaps);
        for (int i = 0; i < PB; i++) begin
            logic [7:0] b;
            b = (i == 0) ? k : (i == 1) ? g : l[(i-2)*8 +: 8];
            if (gaps) begin
                cyc(1'b0, 2'b01, 8'hEE);
                cyc(1'b0, 2'b01, 8'h5A);
            end
            cyc(1'b1, 2'b01, b);
        end
    endtask

    task automatic expect_cfg(input string tag, input logic [7:0] k,
                              input logic [7:0] g, input logic [63:0] l);
        check(tag, 64'(key_len), 64'(k));
        check(tag, 64'(digest_len), 64'(g));
        check(tag, msg_len, l);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < PB; i++) m_buf[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R7: reset values
        check("R7 key", 64'(key_len), 64'd0);
        check("R7 digest", 64'(digest_len), 64'd32);
        check("R7 length", msg_len, 64'd0);
        check("R7 pulse", 64'(cfg_updated), 64'd0);

        // R2: field layout
        send_pkt(8'h20, 8'h10, 64'h0807060504030201, 1'b0);
        cyc(1'b0, 2'b01, 8'h00);
        expect_cfg("R2 layout", 8'h20, 8'h10, 64'h0807060504030201);
        check("R4 pulse after last", 64'(cfg_updated), 64'd1);

        // R1: data, idle and reserved bytes ignored
        for (int i = 0; i < 24; i++) cyc(1'b1, 2'(2 + (i % 2)), 8'(i * 7));
        for (int i = 0; i < 12; i++) cyc(1'b1, 2'b00, 8'hA5);
        cyc(1'b0, 2'b00, 8'h00);
        expect_cfg("R1 other modes", 8'h20, 8'h10, 64'h0807060504030201);

        // R5: partial packet dropped, next packet starts fresh
        for (int i = 0; i < 6; i++) cyc(1'b1, 2'b01, 8'hC0 + 8'(i));
        cyc(1'b1, 2'b10, 8'h77);
        cyc(1'b0, 2'b00, 8'h00);
        expect_cfg("R5 partial dropped", 8'h20, 8'h10, 64'h0807060504030201);
        send_pkt(8'h01, 8'h1C, 64'h00000000DEADBEEF, 1'b0);
        cyc(1'b0, 2'b00, 8'h00);
        expect_cfg("R5 fresh start", 8'h01, 8'h1C, 64'h00000000DEADBEEF);

        // R6: valid gaps inside a packet
        send_pkt(8'h3F, 8'h08, 64'hFEDCBA9876543210, 1'b1);
        cyc(1'b0, 2'b01, 8'h00);
        expect_cfg("R6 gaps", 8'h3F, 8'h08, 64'hFEDCBA9876543210);

        // R8: back-to-back packets, then retention
        send_pkt(8'h11, 8'h22, 64'h1111111111111111, 1'b0);
        check("R8 first pulse", 64'(cfg_updated), 64'd0);
        send_pkt(8'h33, 8'h44, 64'h0123456789ABCDEF, 1'b0);
        cyc(1'b0, 2'b00, 8'h00);
        expect_cfg("R8 second wins", 8'h33, 8'h44, 64'h0123456789ABCDEF);
        for (int i = 0; i < 40; i++) cyc(1'b1, 2'b10, 8'(i));
        cyc(1'b0, 2'b00, 8'h00);
        expect_cfg("R8 retained", 8'h33, 8'h44, 64'h0123456789ABCDEF);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            logic [1:0] m;
            r = int'($urandom % 16);
            m = (r < 11) ? 2'b01 : (r < 14) ? 2'b10 : 2'(r - 14) * 2'd3;
            cyc(($urandom % 4) != 0, m, 8'($urandom));
        end
        cyc(1'b0, 2'b00, 8'h00);
        cyc(1'b0, 2'b00, 8'h00);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule